// File: doc/BRIEF.md
# Prioritised Readout Status Merger

This block takes the 4-bit status codes reported by up to twenty readout devices and reduces them to one merged status code for the trigger throttling logic. Each device code is first classified into one of seven severity classes. Six of these are real device states. The seventh, called illegal, covers every code value that no state defines. Inputs can be excluded individually, so a device known to misbehave cannot disturb the merged result.

Two merge forms are available. In priority form the merged code is that of the most severe class present among the included inputs. In count form the included inputs in one chosen class are counted, and that class is reported only when the count reaches a programmable threshold. A split control runs the block either as one 20-to-1 merger, with the same value on both outputs, or as two independent 10-to-1 mergers, one per output. Each path has a fixed pipeline of four registers.

Top module: `status_merge_top`

## Requirements
- R1: Input codes decode as follows: 4'b1000 Ready, 4'b0100 Busy, 4'b0010 Out-of-sync, 4'b0001 Overflow-warning, 4'b1100 Error, and 4'b0000 or 4'b1111 Disconnected. All nine other values decode as Illegal.
- R2: In priority form (count_mode_i=0) the output reports the most severe class present. The order from most to least severe is Disconnected, Error, Out-of-sync, Busy, Overflow-warning, Illegal, Ready.
- R3: An input whose mask_i bit is 1 has no effect on either output. When all inputs of a merger are masked, that merger outputs Ready, 4'b1000.
- R4: Outputs use the input encoding. Disconnected is sent as 4'b0000 and Illegal as 4'b0011.
- R5: When split_i=1, inputs 0 to 9 drive merged_a_o and inputs 10 to 19 drive merged_b_o. When split_i=0, all inputs are merged and both outputs carry the same code.
- R6: In count form (count_mode_i=1), count_class_i selects a class: 0 Ready, 1 Illegal, 2 Overflow-warning, 3 Busy, 4 Out-of-sync, 5 Error, 6 Disconnected. The merger outputs that class's code when the number of unmasked inputs in that class is at least threshold_i. Otherwise it outputs Ready.
- R7: A change on the inputs or controls just before clock edge k shows on the outputs after edge k+3. The outputs do not change earlier than that.
- R8: A synchronous reset (rst=1 at an edge) sets both outputs to Ready, 4'b1000, at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_code_i | input | 80 | Device codes, input n at bits [4n+3:4n] |
| mask_i | input | 20 | 1 excludes the input from merging |
| split_i | input | 1 | 1 selects two 10-input mergers |
| count_mode_i | input | 1 | 1 selects count-and-threshold form |
| count_class_i | input | 3 | Class counted in count form |
| threshold_i | input | 5 | Count threshold |
| merged_a_o | output | 4 | Merged code, whole block or lower half |
| merged_b_o | output | 4 | Merged code, whole block or upper half |

## Verification
A fault in decoding shows as the wrong class. It appears four edges after the offending code as a wrong output, but only when no more severe state hides it. For that reason the vectors place each state in turn against milder backgrounds. A fault in half selection or mask routing appears as one output disagreeing with the other, or as a masked device showing through, also after four edges. Count faults appear only near the threshold, so thresholds are probed at the count and one above it.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [2:0] {
    CLS_READY   = 3'd0,
    CLS_ILLEGAL = 3'd1,
    CLS_OVF     = 3'd2,
    CLS_BUSY    = 3'd3,
    CLS_OOS     = 3'd4,
    CLS_ERROR   = 3'd5,
    CLS_DISC    = 3'd6
  } sev_cls_e;

  localparam int NCLS = 7;
  localparam logic [3:0] CODE_READY = 4'b1000;

  function automatic logic [3:0] cls_to_code(input logic [2:0] c);
    case (c)
      CLS_ILLEGAL: return 4'b0011;
      CLS_OVF:     return 4'b0001;
      CLS_BUSY:    return 4'b0100;
      CLS_OOS:     return 4'b0010;
      CLS_ERROR:   return 4'b1100;
      CLS_DISC:    return 4'b0000;
      default:     return CODE_READY;
    endcase
  endfunction

  function automatic logic [NCLS-1:0] code_to_vec(input logic [3:0] code);
    logic [NCLS-1:0] v;
    v = '0;
    case (code)
      4'b1000:         v[CLS_READY] = 1'b1;
      4'b0100:         v[CLS_BUSY]  = 1'b1;
      4'b0010:         v[CLS_OOS]   = 1'b1;
      4'b0001:         v[CLS_OVF]   = 1'b1;
      4'b1100:         v[CLS_ERROR] = 1'b1;
      4'b0000, 4'b1111: v[CLS_DISC] = 1'b1;
      default:         v[CLS_ILLEGAL] = 1'b1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/state_decode.sv
module state_decode
  import merge_pkg::*;
#(
  parameter int N = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N*4-1:0]      code_i,
  input  logic [N-1:0]        mask_i,
  output logic [N*NCLS-1:0]   cls_o
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    always_ff @(posedge clk) begin
      if (rst) cls_o[g*NCLS +: NCLS] <= '0;
      else if (mask_i[g]) cls_o[g*NCLS +: NCLS] <= '0;
      else cls_o[g*NCLS +: NCLS] <= code_to_vec(code_i[g*4 +: 4]);
    end

    assert_masked_silent_R3: assert property (@(posedge clk) disable iff (rst)
      mask_i[g] |=> (cls_o[g*NCLS +: NCLS] == '0));
    assert_one_class_R1: assert property (@(posedge clk) disable iff (rst)
      !mask_i[g] |=> ($countones(cls_o[g*NCLS +: NCLS]) == 1));
  end
endmodule

// File: rtl/merge_group.sv
module merge_group
  import merge_pkg::*;
#(
  parameter int GN = 10,
  parameter int CW = 5
) (
  input  logic [GN*NCLS-1:0] cls_i,
  input  logic [2:0]         sel_i,
  output logic [NCLS-1:0]    any_o,
  output logic [CW-1:0]      cnt_o
);
  always_comb begin
    any_o = '0;
    cnt_o = '0;
    for (int i = 0; i < GN; i++) begin
      any_o = any_o | cls_i[i*NCLS +: NCLS];
      if (cls_i[i*NCLS + int'(sel_i)]) cnt_o = cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/out_encode.sv
module out_encode
  import merge_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            count_mode_i,
  input  logic [2:0]      sel_i,
  input  logic [NCLS-1:0] sev_i,
  input  logic            hit_i,
  output logic [3:0]      code_o
);
  logic [2:0] top_cls;

  always_comb begin
    top_cls = CLS_READY;
    for (int c = 0; c < NCLS; c++)
      if (sev_i[c]) top_cls = 3'(c);
  end

  always_ff @(posedge clk) begin
    if (rst) code_o <= CODE_READY;
    else if (count_mode_i) code_o <= hit_i ? cls_to_code(sel_i) : CODE_READY;
    else code_o <= cls_to_code(top_cls);
  end

  assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
    code_o inside {4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b1100, 4'b0000, 4'b0011});
  assert_below_thr_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (count_mode_i && !hit_i) |=> (code_o == CODE_READY));
  assert_empty_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (!count_mode_i && sev_i == '0) |=> (code_o == CODE_READY));
endmodule

// File: rtl/status_merge_top.sv
module status_merge_top
  import merge_pkg::*;
#(
  parameter int N_IN = 20,
  parameter int TW   = $clog2(N_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN*4-1:0] dev_code_i,
  input  logic [N_IN-1:0]   mask_i,
  input  logic              split_i,
  input  logic              count_mode_i,
  input  logic [2:0]        count_class_i,
  input  logic [TW-1:0]     threshold_i,
  output logic [3:0]        merged_a_o,
  output logic [3:0]        merged_b_o
);
  localparam int HALF = N_IN / 2;
  localparam int CW   = TW + 1;

  // stage 1: input capture
  logic [N_IN*4-1:0] code_s1;
  logic [N_IN-1:0]   mask_s1;
  logic              split_s1, mode_s1;
  logic [2:0]        sel_s1;
  logic [TW-1:0]     thr_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_s1 <= '0; mask_s1 <= '1; split_s1 <= 1'b0;
      mode_s1 <= 1'b0; sel_s1 <= '0; thr_s1 <= '0;
    end else begin
      code_s1 <= dev_code_i; mask_s1 <= mask_i; split_s1 <= split_i;
      mode_s1 <= count_mode_i; sel_s1 <= count_class_i; thr_s1 <= threshold_i;
    end
  end

  // stage 2: decode
  logic [N_IN*NCLS-1:0] cls_s2;
  logic                 split_s2, mode_s2;
  logic [2:0]           sel_s2;
  logic [TW-1:0]        thr_s2;

  state_decode #(.N(N_IN)) u_dec (
    .clk(clk), .rst(rst), .code_i(code_s1), .mask_i(mask_s1), .cls_o(cls_s2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      split_s2 <= 1'b0; mode_s2 <= 1'b0; sel_s2 <= '0; thr_s2 <= '0;
    end else begin
      split_s2 <= split_s1; mode_s2 <= mode_s1; sel_s2 <= sel_s1; thr_s2 <= thr_s1;
    end
  end

  // stage 3: merge per half
  logic [NCLS-1:0] any_lo, any_hi;
  logic [CW-1:0]   cnt_lo, cnt_hi, cnt_all;

  merge_group #(.GN(HALF), .CW(CW)) u_grp_lo (
    .cls_i(cls_s2[HALF*NCLS-1:0]), .sel_i(sel_s2), .any_o(any_lo), .cnt_o(cnt_lo)
  );
  merge_group #(.GN(N_IN-HALF), .CW(CW)) u_grp_hi (
    .cls_i(cls_s2[N_IN*NCLS-1:HALF*NCLS]), .sel_i(sel_s2), .any_o(any_hi), .cnt_o(cnt_hi)
  );

  assign cnt_all = cnt_lo + cnt_hi;

  logic [NCLS-1:0] sev_a_s3, sev_b_s3;
  logic            hit_a_s3, hit_b_s3, split_s3, mode_s3;
  logic [2:0]      sel_s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      sev_a_s3 <= '0; sev_b_s3 <= '0; hit_a_s3 <= 1'b0; hit_b_s3 <= 1'b0;
      split_s3 <= 1'b0; mode_s3 <= 1'b0; sel_s3 <= '0;
    end else begin
      if (split_s2) begin
        sev_a_s3 <= any_lo;
        sev_b_s3 <= any_hi;
        hit_a_s3 <= cnt_lo >= CW'(thr_s2);
        hit_b_s3 <= cnt_hi >= CW'(thr_s2);
      end else begin
        sev_a_s3 <= any_lo | any_hi;
        sev_b_s3 <= any_lo | any_hi;
        hit_a_s3 <= cnt_all >= CW'(thr_s2);
        hit_b_s3 <= cnt_all >= CW'(thr_s2);
      end
      split_s3 <= split_s2; mode_s3 <= mode_s2; sel_s3 <= sel_s2;
    end
  end

  // stage 4: encode
  out_encode u_enc_a (
    .clk(clk), .rst(rst), .count_mode_i(mode_s3), .sel_i(sel_s3),
    .sev_i(sev_a_s3), .hit_i(hit_a_s3), .code_o(merged_a_o)
  );
  out_encode u_enc_b (
    .clk(clk), .rst(rst), .count_mode_i(mode_s3), .sel_i(sel_s3),
    .sev_i(sev_b_s3), .hit_i(hit_b_s3), .code_o(merged_b_o)
  );

  assert_joined_equal_R5: assert property (@(posedge clk) disable iff (rst)
    !split_s3 |=> (merged_a_o == merged_b_o));
  assert_reset_ready_R8: assert property (@(posedge clk)
    rst |=> (merged_a_o == CODE_READY && merged_b_o == CODE_READY));
endmodule

// File: tb/status_merge_top_bench.sv
module status_merge_top_bench;
  localparam int N = 20;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*4-1:0] dev_code;
  logic [N-1:0]  mask;
  logic          split, cmode;
  logic [2:0]    csel;
  logic [4:0]    thr;
  logic [3:0]    out_a, out_b;
  int            n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  status_merge_top u_status_merge_top (
    .clk(clk), .rst(rst), .dev_code_i(dev_code), .mask_i(mask), .split_i(split),
    .count_mode_i(cmode), .count_class_i(csel), .threshold_i(thr),
    .merged_a_o(out_a), .merged_b_o(out_b)
  );

  // vector fields: background code, two placed codes, mask, controls, expectations
  localparam logic [3:0] V_BG  [NV] = '{4'h8,4'h8,4'h8,4'h8,4'h8,4'h8,4'h8,4'h8,4'h0,4'h8,4'h8,4'h8,4'h8,4'h8,4'h7,4'h8};
  localparam int         V_I0  [NV] = '{0,3,3,2,0,5,5,4,0,1,1,1,1,1,0,9};
  localparam logic [3:0] V_C0  [NV] = '{4'h8,4'h1,4'h1,4'h5,4'hF,4'h2,4'h2,4'hC,4'h0,4'h4,4'h4,4'h4,4'h4,4'h4,4'h7,4'h2};
  localparam int         V_I1  [NV] = '{0,15,15,12,19,6,7,11,0,14,14,14,14,14,0,10};
  localparam logic [3:0] V_C1  [NV] = '{4'h8,4'h4,4'h4,4'h1,4'hC,4'hC,4'h4,4'h0,4'h0,4'h4,4'h4,4'h4,4'h4,4'h4,4'h7,4'h5};
  localparam logic [19:0] V_MK [NV] = '{20'h0,20'h0,20'h0,20'h0,20'h0,20'h0,20'h0,20'h00810,20'hFFFFF,
                                         20'h0,20'h0,20'h0,20'h0,20'h00002,20'h0,20'h0};
  localparam logic       V_SP  [NV] = '{0,0,1,1,0,0,0,0,0,0,0,1,1,1,1,1};
  localparam logic       V_CM  [NV] = '{0,0,0,0,0,0,0,0,0,1,1,1,1,1,0,0};
  localparam logic [2:0] V_SEL [NV] = '{0,0,0,0,0,0,0,0,0,3,3,3,3,3,0,0};
  localparam logic [4:0] V_THR [NV] = '{0,0,0,0,0,0,0,0,0,2,3,1,2,1,0,0};
  localparam logic [3:0] V_EA  [NV] = '{4'h8,4'h4,4'h1,4'h3,4'h0,4'hC,4'h2,4'h8,4'h8,4'h4,4'h8,4'h4,4'h8,4'h8,4'h3,4'h2};
  localparam logic [3:0] V_EB  [NV] = '{4'h8,4'h4,4'h4,4'h1,4'h0,4'hC,4'h2,4'h8,4'h8,4'h4,4'h8,4'h4,4'h8,4'h4,4'h3,4'h3};
  localparam string      V_REQ [NV] = '{"R1","R2","R5","R4","R4","R2","R2","R3","R3",
                                         "R6","R6","R6","R6","R3","R1","R5"};

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive_vec(input int v);
    for (int i = 0; i < N; i++) dev_code[i*4 +: 4] = V_BG[v];
    dev_code[V_I0[v]*4 +: 4] = V_C0[v];
    dev_code[V_I1[v]*4 +: 4] = V_C1[v];
    mask = V_MK[v]; split = V_SP[v]; cmode = V_CM[v]; csel = V_SEL[v]; thr = V_THR[v];
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive_vec(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", out_a, 4'b1000);
    check("R8", out_b, 4'b1000);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_vec(v);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(V_REQ[v], out_a, V_EA[v]);
      check(V_REQ[v], out_b, V_EB[v]);
    end

    // R7: latency is exactly four edges
    @(negedge clk); drive_vec(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    dev_code[0 +: 4] = 4'b1100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", out_a, 4'b1000);
    @(posedge clk);
    @(negedge clk);
    check("R7", out_a, 4'b1100);
    check("R7", out_b, 4'b1100);

    // R8: reset during a non-Ready output
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", out_a, 4'b1000);
    check("R8", out_b, 4'b1000);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule